// File: doc/BRIEF.md
# Semaphore-Checking Shared Memory Gatekeeper

The gatekeeper sits between one processor and a bus that is shared with other processors. It turns a shared-memory transfer that is synchronised by a full/empty flag into a single hardware operation. Each shared word has a one-bit flag stored with it. The block wins the bus, reads the word and its flag, and decides whether the access may go ahead. If it may not, the block gives the bus back and tries again after a programmable pause. Software never sees any of this.

Reads stall the processor until the flag shows full. The block then returns the word and marks the location empty. Writes are posted into a one-entry buffer, so the processor keeps running. The buffered write completes in the background once the flag shows empty, and it leaves the location marked full. Each location has exactly one producer and one consumer, so no indivisible read-modify-write is needed. The bus arbiter and the memory are outside the block.

Top module: `shm_gatekeeper`

## Requirements
- R1: After reset, `bus_req`, `mem_en` and `cpu_wait` are low while `cpu_req` is low.
- R2: A write request that finds the post buffer empty is accepted with `cpu_wait` low in that cycle, so the processor is not stalled.
- R3: Any request presented while a posted write is still pending sees `cpu_wait` high until that write has been committed to memory.
- R4: A write commits only after a probe has found the flag empty (`mem_rflag` = 0). The commit stores the data and writes the flag as full (`mem_fset` = 1). While the flag reads full, the location's data is left unchanged.
- R5: A read completes only after a probe has found the flag full (`mem_rflag` = 1). Its commit writes only the flag, to empty (`mem_fset` = 0), and leaves the data as it was.
- R6: After a probe that fails, `bus_req` drops in the next cycle and stays low for exactly `cfg_backoff`+1 cycles before the block requests the bus again.
- R7: `mem_en` is never high unless `bus_gnt` is high. `bus_req` stays high from the request until the attempt ends, including while the grant is delayed.
- R8: A read request sees `cpu_wait` high until the cycle in which `cpu_rdata` carries the word that was stored in the location. In that cycle `cpu_wait` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_backoff | input | BO_W | Idle cycles minus one between a failed check and the next bus request |
| cpu_req | input | 1 | Processor shared access request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Shared-space word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_wait | output | 1 | Stall: the request is not completed at the coming edge |
| cpu_rdata | output | DATA_W | Read data, valid when a read sees `cpu_wait` low |
| bus_req | output | 1 | Bus request to the external arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_en | output | 1 | Memory access strobe |
| mem_dwe | output | 1 | Data word write enable |
| mem_fwe | output | 1 | Flag write enable |
| mem_fset | output | 1 | Flag value to write (1 = full) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after a read strobe |
| mem_rflag | input | 1 | Flag read back with `mem_rdata` |

## Verification
The internal state here is the engine state, the post buffer and the back-off count. Each shows at the ports within a few cycles. A stuck post buffer holds `cpu_wait` high on the next request. A wrong flag decision writes memory, or fails to, on the commit cycle right after the probe. A miscounted pause changes the length of the low stretch of `bus_req` between attempts. The bench keeps its own behavioural memory and arbiter. It watches every clock for accesses without a grant and for flag writes. It also measures each gap between bus attempts and compares the read data and stall behaviour with what the requirements predict.

// File: rtl/gk_pkg.sv
package gk_pkg;
  typedef enum logic [2:0] {
    GK_IDLE,
    GK_ARB,
    GK_PROBE,
    GK_TEST,
    GK_COMMIT,
    GK_BACK
  } gk_state_t;
endpackage

// File: rtl/gk_backoff.sv
module gk_backoff #(
  parameter int BO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BO_W-1:0] span,
  output logic            expired
);
  logic [BO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= span;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R6: a non-zero count decreases by exactly one per cycle unless reloaded
  a_r6_count_steps: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/gk_post_buf.sv
module gk_post_buf #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else begin
      if (push) begin
        valid <= 1'b1;
        addr  <= push_addr;
        data  <= push_data;
      end else if (pop) begin
        valid <= 1'b0;
      end
    end
  end

  // R3: a single entry never takes a second push
  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    push |-> !valid);
  // R2: an accepted push is held until popped
  a_r2_push_lands: assert property (@(posedge clk) disable iff (rst)
    push |=> valid);
endmodule

// File: rtl/gk_engine.sv
module gk_engine
  import gk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int BO_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              launch_we,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic [DATA_W-1:0] launch_data,
  input  logic [BO_W-1:0]   cfg_backoff,
  output logic              busy,
  output logic              done_wr,
  output logic              done_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_en,
  output logic              mem_dwe,
  output logic              mem_fwe,
  output logic              mem_fset,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rflag
);
  gk_state_t         state;
  logic              op_we;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic              pass;
  logic              bo_load;
  logic              bo_expired;

  // write wants an empty flag, read wants a full one
  assign pass    = op_we ? !mem_rflag : mem_rflag;
  assign bo_load = (state == GK_TEST) && !pass;

  gk_backoff #(.BO_W(BO_W)) u_backoff (
    .clk     (clk),
    .rst     (rst),
    .load    (bo_load),
    .span    (cfg_backoff),
    .expired (bo_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= GK_IDLE;
      op_we   <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
      rd_data <= '0;
    end else begin
      case (state)
        GK_IDLE: if (launch) begin
          op_we   <= launch_we;
          op_addr <= launch_addr;
          op_data <= launch_data;
          state   <= GK_ARB;
        end
        GK_ARB:   if (bus_gnt) state <= GK_PROBE;
        GK_PROBE: state <= GK_TEST;
        GK_TEST: begin
          if (pass) begin
            if (!op_we) rd_data <= mem_rdata;
            state <= GK_COMMIT;
          end else begin
            state <= GK_BACK;
          end
        end
        GK_COMMIT: state <= GK_IDLE;
        GK_BACK:   if (bo_expired) state <= GK_ARB;
        default:   state <= GK_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req   = (state == GK_ARB) || (state == GK_PROBE) ||
                (state == GK_TEST) || (state == GK_COMMIT);
    mem_en    = (state == GK_PROBE) || (state == GK_COMMIT);
    mem_dwe   = (state == GK_COMMIT) && op_we;
    mem_fwe   = (state == GK_COMMIT);
    mem_fset  = op_we;
    mem_addr  = op_addr;
    mem_wdata = op_data;
    done_wr   = (state == GK_COMMIT) && op_we;
    done_rd   = (state == GK_COMMIT) && !op_we;
    busy      = (state != GK_IDLE);
  end

  // R7: memory is touched only under grant
  a_r7_access_needs_grant: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> bus_gnt);
  // R7: request stays up while waiting for the grant
  a_r7_hold_request: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> bus_req);
  // R4: data is written only after an empty flag was read, and marks full
  a_r4_write_on_empty: assert property (@(posedge clk) disable iff (rst)
    mem_dwe |-> (!$past(mem_rflag) && mem_fset && mem_fwe));
  // R5: a read clears the flag only after it was seen full
  a_r5_read_on_full: assert property (@(posedge clk) disable iff (rst)
    (mem_fwe && !mem_dwe) |-> ($past(mem_rflag) && !mem_fset));
  // R6: a failed check gives the bus back at once
  a_r6_release_after_fail: assert property (@(posedge clk) disable iff (rst)
    bo_load |=> !bus_req);
endmodule

// File: rtl/shm_gatekeeper.sv
module shm_gatekeeper #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int BO_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BO_W-1:0]   cfg_backoff,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_wait,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_en,
  output logic              mem_dwe,
  output logic              mem_fwe,
  output logic              mem_fset,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rflag
);
  logic              wb_valid;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic              wb_push;
  logic              eng_busy;
  logic              done_wr;
  logic              done_rd;
  logic              rd_ready;
  logic              launch_wr;
  logic              launch_rd;
  logic              launch;
  logic [ADDR_W-1:0] launch_addr;

  assign wb_push     = cpu_req && cpu_we && !wb_valid;
  assign launch_wr   = !eng_busy && wb_valid;
  assign launch_rd   = !eng_busy && !wb_valid && cpu_req && !cpu_we && !rd_ready;
  assign launch      = launch_wr || launch_rd;
  assign launch_addr = launch_wr ? wb_addr : cpu_addr;

  gk_post_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_post (
    .clk       (clk),
    .rst       (rst),
    .push      (wb_push),
    .push_addr (cpu_addr),
    .push_data (cpu_wdata),
    .pop       (done_wr),
    .valid     (wb_valid),
    .addr      (wb_addr),
    .data      (wb_data)
  );

  gk_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BO_W(BO_W)) u_engine (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch),
    .launch_we   (launch_wr),
    .launch_addr (launch_addr),
    .launch_data (wb_data),
    .cfg_backoff (cfg_backoff),
    .busy        (eng_busy),
    .done_wr     (done_wr),
    .done_rd     (done_rd),
    .rd_data     (cpu_rdata),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .mem_en      (mem_en),
    .mem_dwe     (mem_dwe),
    .mem_fwe     (mem_fwe),
    .mem_fset    (mem_fset),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_rflag   (mem_rflag)
  );

  // read result is presented until the processor takes it
  always_ff @(posedge clk) begin
    if (rst) rd_ready <= 1'b0;
    else if (done_rd) rd_ready <= 1'b1;
    else if (cpu_req && !cpu_we && rd_ready) rd_ready <= 1'b0;
  end

  assign cpu_wait = cpu_req && (wb_valid || (!cpu_we && !rd_ready));

  // R3: the pending write blocks every new request
  a_r3_stall_on_pending: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && wb_valid) |-> cpu_wait);
  // R8: a read is released only once its data was committed
  a_r8_read_release: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_we && !cpu_wait) |-> $past(done_rd) || $past(rd_ready));
endmodule

// File: tb/shm_gatekeeper_bench.sv
module shm_gatekeeper_bench;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [BW-1:0] cfg_backoff = 8'd5;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_wait;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req;
  logic          bus_gnt = 1'b0;
  logic          mem_en, mem_dwe, mem_fwe, mem_fset;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_rflag = 1'b0;

  always #2 clk = ~clk;

  shm_gatekeeper #(.ADDR_W(AW), .DATA_W(DW), .BO_W(BW)) u_shm_gatekeeper (
    .clk(clk), .rst(rst), .cfg_backoff(cfg_backoff),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wait(cpu_wait), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_en(mem_en), .mem_dwe(mem_dwe), .mem_fwe(mem_fwe), .mem_fset(mem_fset),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rflag(mem_rflag)
  );

  // behavioural shared memory and arbiter
  logic [DW-1:0] mdata [16];
  logic          mflag [16];
  int            gdelay = 0;
  int            gcnt = 0;

  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= mdata[mem_addr];
      mem_rflag <= mflag[mem_addr];
      if (mem_dwe) mdata[mem_addr] <= mem_wdata;
      if (mem_fwe) mflag[mem_addr] <= mem_fset;
    end
    if (bus_req) begin
      gcnt    <= gcnt + 1;
      bus_gnt <= (gcnt >= gdelay);
    end else begin
      gcnt    <= 0;
      bus_gnt <= 1'b0;
    end
  end

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock monitor: grant rule and gap lengths between bus attempts
  int grant_viol = 0;
  int lowrun = 0;
  int gaps[$];
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_en && !bus_gnt) grant_viol++;
      if (!bus_req) lowrun++;
      else begin
        if (lowrun > 0) gaps.push_back(lowrun);
        lowrun = 0;
      end
    end
  end

  // issue one access, return stall cycles and read data
  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int stalls, output logic [DW-1:0] rd);
    stalls = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    forever begin
      #1;
      if (!cpu_wait) begin
        rd = cpu_rdata;
        @(posedge clk);
        break;
      end
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int st;
    logic [DW-1:0] rd;
    for (int i = 0; i < 16; i++) begin mdata[i] = '0; mflag[i] = 1'b0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check(bus_req == 1'b0, "R1 bus_req", bus_req, 0);
    check(mem_en == 1'b0, "R1 mem_en", mem_en, 0);
    check(cpu_wait == 1'b0, "R1 cpu_wait", cpu_wait, 0);

    // R2 posted write, R4 lands as full
    access(1'b1, 4'd3, 16'hA5A5, st, rd);
    check(st == 0, "R2 write not stalled", st, 0);
    idle(12);
    check(mdata[3] == 16'hA5A5, "R4 write data stored", mdata[3], 16'hA5A5);
    check(mflag[3] == 1'b1, "R4 flag set full", mflag[3], 1);

    // R3 read right behind a posted write, R5/R8 read returns and empties
    access(1'b1, 4'd6, 16'h1234, st, rd);
    check(st == 0, "R2 second write not stalled", st, 0);
    access(1'b0, 4'd6, 16'h0, st, rd);
    check(st >= 4, "R3 stall behind pending write", st, 4);
    check(rd == 16'h1234, "R8 read data", rd, 16'h1234);
    idle(2);
    check(mflag[6] == 1'b0, "R5 flag cleared by read", mflag[6], 0);
    check(mdata[6] == 16'h1234, "R5 data untouched by read", mdata[6], 16'h1234);

    // R4 write to a full location is held off; R3 next request stalls
    mflag[9] = 1'b1; mdata[9] = 16'h0BAD;
    access(1'b1, 4'd9, 16'h7777, st, rd);
    check(st == 0, "R2 write to full not stalled", st, 0);
    idle(30);
    check(mdata[9] == 16'h0BAD, "R4 no write while full", mdata[9], 16'h0BAD);
    fork
      begin
        int s2;
        logic [DW-1:0] r2;
        access(1'b1, 4'd10, 16'h2222, s2, r2);
        check(s2 >= 20, "R3 request waits for pending write", s2, 20);
      end
      begin
        idle(20);
        mflag[9] = 1'b0;
      end
    join
    idle(20);
    check(mdata[9] == 16'h7777, "R4 write after empty", mdata[9], 16'h7777);
    check(mflag[10] == 1'b1, "R4 queued write landed", mflag[10], 1);

    // R6 back-off gaps for two settings, with a delayed grant (R7)
    for (int k = 0; k < 2; k++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] v;
      cfg_backoff = (k == 0) ? 8'd5 : 8'd0;
      gdelay = (k == 0) ? 0 : 3;
      a = (k == 0) ? 4'd12 : 4'd13;
      v = (k == 0) ? 16'hBEEF : 16'hCAFE;
      idle(3);
      gaps.delete();
      fork
        access(1'b0, a, 16'h0, st, rd);
        begin
          idle(40);
          mdata[a] = v;
          mflag[a] = 1'b1;
        end
      join
      check(rd == v, "R8 read after retries", rd, v);
      check(st >= 40, "R5 read stalled while empty", st, 40);
      check(gaps.size() >= 3, "R6 retries seen", gaps.size(), 3);
      for (int g = 1; g < gaps.size(); g++)
        check(gaps[g] == int'(cfg_backoff) + 1, "R6 back-off gap", gaps[g], int'(cfg_backoff) + 1);
    end

    check(grant_viol == 0, "R7 access without grant", grant_viol, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule